// File: doc/BRIEF.md
# Branch and Next-PC Unit

This block picks the address of the next instruction for a 16-bit processor that has byte-addressed memory and 16-bit instruction words. Each cycle it receives the address of the current instruction, a decoded control-flow kind, the immediate or displacement word, the value read from a general register, and the zero and less-than status flags. From these it returns the next program counter and a taken indication. For the jump-and-link kind it also returns a write request that places the return address into register 15.

There are three groups of control-flow kind. Conditional branches are PC-relative: two of them test the zero flag and two test the less-than flag. The absolute jumps are the plain jump and the jump-and-link. The last kind is a jump to the address held in a register. When no control-flow change is taken, the counter steps past the instruction, and it steps past the extension word too when that word is present. An 8-bit page register is loaded by its own strobe. It forms the upper part of the 24-bit fetch address, with the 16-bit next PC below it. The next-PC path is purely combinational, and the page register is the only state in the block.

Top module: `bru_nextpc`

## Requirements
- R1: The kind code on `kind_i` is decoded as follows: 0 means sequential, 1 means branch if zero set, 2 means branch if zero clear, 3 means branch if less-than set, 4 means branch if less-than clear, 5 means absolute jump, 6 means jump-and-link, and 7 means jump to register. For kind 0 and for any untaken branch, `next_pc_o` is `pc_i`+2 when `ext_i` is 0 and `pc_i`+4 when `ext_i` is 1, and `taken_o` is 0.
- R2: Kind 1 is taken exactly when `zf_i` is 1, and kind 2 is taken exactly when `zf_i` is 0. When taken, `next_pc_o` = `pc_i` + `imm_i` and `taken_o` = 1. `ltf_i` has no effect on these kinds.
- R3: Kind 3 is taken exactly when `ltf_i` is 1, and kind 4 is taken exactly when `ltf_i` is 0. The target is the same PC-relative one as in R2, and `zf_i` has no effect on these kinds.
- R4: The displacement is a signed two's-complement value. It is added to the address of the branch instruction itself, and the sum wraps modulo 2^16 in both directions.
- R5: Kind 5 always gives `taken_o` = 1 and `next_pc_o` = `imm_i`, whatever the flags and `ext_i` are.
- R6: Kind 6 gives `next_pc_o` = `imm_i` and `taken_o` = 1. It also raises `link_we_o`, with `link_idx_o` = 15 and `link_val_o` = `pc_i`+2 taken modulo 2^16.
- R7: Kind 7 always gives `taken_o` = 1 and `next_pc_o` = `reg_i`, and `imm_i` has no effect.
- R8: `link_we_o` is 0 for every kind other than 6.
- R9: The page register resets to 0. It takes the value of `page_val_i` on a rising clock edge where `page_ld_i` is 1, and it holds its value otherwise. `fetch_addr_o` is the page in bits 23:16 with `next_pc_o` in bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the page register |
| rst_n | input | 1 | Active-low asynchronous reset |
| pc_i | input | 16 | Address of the current instruction |
| kind_i | input | 3 | Decoded control-flow kind |
| ext_i | input | 1 | Extension word follows the instruction |
| imm_i | input | 16 | Displacement or absolute target |
| reg_i | input | 16 | Register value used as the jump-to-register target |
| zf_i | input | 1 | Zero status flag |
| ltf_i | input | 1 | Less-than status flag |
| page_ld_i | input | 1 | Load strobe for the page register |
| page_val_i | input | 8 | Value to load into the page register |
| next_pc_o | output | 16 | Next program counter |
| taken_o | output | 1 | Control flow leaves the sequential path |
| link_we_o | output | 1 | Write request for the return address |
| link_idx_o | output | 4 | Register index for the return address |
| link_val_o | output | 16 | Return address |
| fetch_addr_o | output | 24 | Page concatenated with the next PC |
| page_o | output | 8 | Current page register value |

## Verification
Each conditional kind is driven twice, once with its flag set and once with it clear. The other flag is held at the value that would flip the outcome if it were wrongly used, and this catches a branch that looks at the wrong flag. Displacements are run both forward and backward, from PCs near zero and near the top of the range, so that sign extension and 16-bit wrap are each tested on their own. The absolute kinds and the register kind are driven with `imm_i` and `reg_i` set to different values, which shows which source is selected. The link output is checked for every kind, so that a write request raised by the wrong kind is detected.

// File: rtl/bru_pkg.sv
package bru_pkg;

   typedef enum logic [2:0] {
      K_SEQ   = 3'd0,
      K_IFZ   = 3'd1,
      K_IFNZ  = 3'd2,
      K_IFLT  = 3'd3,
      K_IFNLT = 3'd4,
      K_JABS  = 3'd5,
      K_JLINK = 3'd6,
      K_JREG  = 3'd7
   } kind_e;

   localparam int KIND_W = 3;

endpackage

// File: rtl/bru_cond_eval.sv
module bru_cond_eval
   import bru_pkg::*;
(
   input  kind_e kind,
   input  logic  zf,
   input  logic  ltf,
   output logic  cond_take,
   output logic  uncond,
   output logic  use_reg,
   output logic  link
);

   always_comb begin
      cond_take = 1'b0;
      uncond    = 1'b0;
      use_reg   = 1'b0;
      link      = 1'b0;
      unique case (kind)
         K_IFZ:   cond_take = zf;
         K_IFNZ:  cond_take = ~zf;
         K_IFLT:  cond_take = ltf;
         K_IFNLT: cond_take = ~ltf;
         K_JABS:  uncond    = 1'b1;
         K_JLINK: begin
            uncond = 1'b1;
            link   = 1'b1;
         end
         K_JREG: begin
            uncond  = 1'b1;
            use_reg = 1'b1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/bru_target_gen.sv
module bru_target_gen #(
   parameter int PC_W       = 16,
   parameter int OFS_W      = 16,
   parameter int INSN_BYTES = 2
) (
   input  logic [PC_W-1:0]  pc,
   input  logic             ext,
   input  logic [OFS_W-1:0] ofs,
   output logic [PC_W-1:0]  seq_pc,
   output logic [PC_W-1:0]  rel_pc,
   output logic [PC_W-1:0]  ret_pc
);

   localparam logic [PC_W-1:0] STEP_ONE = PC_W'(INSN_BYTES);
   localparam logic [PC_W-1:0] STEP_TWO = PC_W'(2 * INSN_BYTES);

   logic [PC_W-1:0] ofs_ext;

   generate
      if (OFS_W > PC_W) begin : g_bad_ofs
         $error("bru_target_gen: OFS_W must not exceed PC_W");
      end
      if (INSN_BYTES < 1) begin : g_bad_step
         $error("bru_target_gen: INSN_BYTES must be at least 1");
      end
      if (OFS_W == PC_W) begin : g_ofs_full
         assign ofs_ext = ofs;
      end else begin : g_ofs_sext
         assign ofs_ext = {{(PC_W-OFS_W){ofs[OFS_W-1]}}, ofs};
      end
   endgenerate

   assign seq_pc = pc + (ext ? STEP_TWO : STEP_ONE);
   assign rel_pc = pc + ofs_ext;
   assign ret_pc = pc + STEP_ONE;

endmodule

// File: rtl/bru_page_reg.sv
module bru_page_reg #(
   parameter int PG_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ld,
   input  logic [PG_W-1:0] val,
   output logic [PG_W-1:0] q
);

   generate
      if (PG_W < 1) begin : g_bad_pg
         $error("bru_page_reg: PG_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (ld) q <= val;
   end

   AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> $stable(q)); // R9
   AST_PAGE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> q == $past(val)); // R9

endmodule

// File: rtl/bru_nextpc.sv
module bru_nextpc
   import bru_pkg::*;
#(
   parameter int PC_W       = 16,
   parameter int OFS_W      = 16,
   parameter int PG_W       = 8,
   parameter int INSN_BYTES = 2,
   parameter int RIDX_W     = 4,
   parameter int LINK_REG   = 15
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [PC_W-1:0]      pc_i,
   input  logic [KIND_W-1:0]    kind_i,
   input  logic                 ext_i,
   input  logic [OFS_W-1:0]     imm_i,
   input  logic [PC_W-1:0]      reg_i,
   input  logic                 zf_i,
   input  logic                 ltf_i,
   input  logic                 page_ld_i,
   input  logic [PG_W-1:0]      page_val_i,
   output logic [PC_W-1:0]      next_pc_o,
   output logic                 taken_o,
   output logic                 link_we_o,
   output logic [RIDX_W-1:0]    link_idx_o,
   output logic [PC_W-1:0]      link_val_o,
   output logic [PG_W+PC_W-1:0] fetch_addr_o,
   output logic [PG_W-1:0]      page_o
);

   localparam int ADDR_W = PG_W + PC_W;
   localparam logic [PC_W-1:0] STEP_ONE = PC_W'(INSN_BYTES);
   localparam logic [PC_W-1:0] STEP_TWO = PC_W'(2 * INSN_BYTES);

   generate
      if (LINK_REG >= (1 << RIDX_W)) begin : g_bad_link
         $error("bru_nextpc: LINK_REG does not fit in RIDX_W bits");
      end
      if (ADDR_W < PC_W) begin : g_bad_addr
         $error("bru_nextpc: address width below PC width");
      end
   endgenerate

   kind_e           kind;
   logic            cond_take, uncond, use_reg, link;
   logic [PC_W-1:0] seq_pc, rel_pc, ret_pc;
   logic [PC_W-1:0] abs_pc;

   assign kind = kind_e'(kind_i);

   bru_cond_eval u_cond (
      .kind      (kind),
      .zf        (zf_i),
      .ltf       (ltf_i),
      .cond_take (cond_take),
      .uncond    (uncond),
      .use_reg   (use_reg),
      .link      (link)
   );

   bru_target_gen #(
      .PC_W       (PC_W),
      .OFS_W      (OFS_W),
      .INSN_BYTES (INSN_BYTES)
   ) u_tgt (
      .pc     (pc_i),
      .ext    (ext_i),
      .ofs    (imm_i),
      .seq_pc (seq_pc),
      .rel_pc (rel_pc),
      .ret_pc (ret_pc)
   );

   bru_page_reg #(
      .PG_W (PG_W)
   ) u_page (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    (page_ld_i),
      .val   (page_val_i),
      .q     (page_o)
   );

   generate
      if (OFS_W == PC_W) begin : g_abs_full
         assign abs_pc = imm_i;
      end else begin : g_abs_zext
         assign abs_pc = {{(PC_W-OFS_W){1'b0}}, imm_i};
      end
   endgenerate

   always_comb begin
      if (uncond)         next_pc_o = use_reg ? reg_i : abs_pc;
      else if (cond_take) next_pc_o = rel_pc;
      else                next_pc_o = seq_pc;
   end

   assign taken_o      = uncond | cond_take;
   assign link_we_o    = link;
   assign link_idx_o   = RIDX_W'(LINK_REG);
   assign link_val_o   = ret_pc;
   assign fetch_addr_o = {page_o, next_pc_o};

   AST_FALLTHRU_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !taken_o |-> next_pc_o == pc_i + (ext_i ? STEP_TWO : STEP_ONE)); // R1
   AST_JUMP_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i >= 3'd5) |-> taken_o); // R5
   AST_LINK_KIND: assert property (@(posedge clk) disable iff (!rst_n)
      link_we_o |-> kind_i == 3'd6); // R8
   AST_LINK_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
      link_we_o |-> link_val_o == pc_i + STEP_ONE); // R6
   AST_REG_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i == 3'd7) |-> next_pc_o == reg_i); // R7

endmodule

// File: tb/sim_bru_nextpc.sv
`timescale 1ns/1ps
module sim_bru_nextpc;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] pc_i = '0;
   logic [2:0]  kind_i = '0;
   logic        ext_i = 1'b0;
   logic [15:0] imm_i = '0;
   logic [15:0] reg_i = '0;
   logic        zf_i = 1'b0;
   logic        ltf_i = 1'b0;
   logic        page_ld_i = 1'b0;
   logic [7:0]  page_val_i = '0;
   logic [15:0] next_pc_o;
   logic        taken_o;
   logic        link_we_o;
   logic [3:0]  link_idx_o;
   logic [15:0] link_val_o;
   logic [23:0] fetch_addr_o;
   logic [7:0]  page_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   bru_nextpc u0 (
      .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .kind_i(kind_i), .ext_i(ext_i),
      .imm_i(imm_i), .reg_i(reg_i), .zf_i(zf_i), .ltf_i(ltf_i),
      .page_ld_i(page_ld_i), .page_val_i(page_val_i),
      .next_pc_o(next_pc_o), .taken_o(taken_o), .link_we_o(link_we_o),
      .link_idx_o(link_idx_o), .link_val_o(link_val_o),
      .fetch_addr_o(fetch_addr_o), .page_o(page_o)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(logic [2:0] k, logic [15:0] pc, logic [15:0] imm,
                        logic ext, logic z, logic lt, logic [15:0] rv);
      @(negedge clk);
      kind_i = k; pc_i = pc; imm_i = imm; ext_i = ext;
      zf_i = z; ltf_i = lt; reg_i = rv;
      #1;
   endtask

   task automatic t_reset;
      chk("R9 reset page", {24'd0, page_o}, 32'h0);
      chk("R9 reset fetch upper", {24'd0, fetch_addr_o[23:16]}, 32'h0);
   endtask

   task automatic t_sequential;
      drive(3'd0, 16'h1000, 16'h0040, 1'b0, 1'b1, 1'b1, 16'h0);
      chk("R1 seq step2", {16'd0, next_pc_o}, 32'h1002);
      chk("R1 seq taken", {31'd0, taken_o}, 32'h0);
      drive(3'd0, 16'h1000, 16'h0040, 1'b1, 1'b1, 1'b1, 16'h0);
      chk("R1 seq step4", {16'd0, next_pc_o}, 32'h1004);
      drive(3'd0, 16'hFFFE, 16'h0, 1'b0, 1'b0, 1'b0, 16'h0);
      chk("R1 seq wrap", {16'd0, next_pc_o}, 32'h0000);
      drive(3'd0, 16'hFFFE, 16'h0, 1'b1, 1'b0, 1'b0, 16'h0);
      chk("R1 seq wrap ext", {16'd0, next_pc_o}, 32'h0002);
   endtask

   task automatic t_zero_flag;
      drive(3'd1, 16'h0200, 16'h0040, 1'b0, 1'b1, 1'b0, 16'h0);
      chk("R2 ifz taken pc", {16'd0, next_pc_o}, 32'h0240);
      chk("R2 ifz taken", {31'd0, taken_o}, 32'h1);
      drive(3'd1, 16'h0200, 16'h0040, 1'b1, 1'b0, 1'b1, 16'h0);
      chk("R2 ifz not taken pc", {16'd0, next_pc_o}, 32'h0204);
      chk("R2 ifz not taken", {31'd0, taken_o}, 32'h0);
      drive(3'd2, 16'h0200, 16'h0040, 1'b0, 1'b0, 1'b1, 16'h0);
      chk("R2 ifnz taken pc", {16'd0, next_pc_o}, 32'h0240);
      drive(3'd2, 16'h0200, 16'h0040, 1'b0, 1'b1, 1'b0, 16'h0);
      chk("R2 ifnz not taken pc", {16'd0, next_pc_o}, 32'h0202);
      chk("R2 ifnz not taken", {31'd0, taken_o}, 32'h0);
   endtask

   task automatic t_lt_flag;
      drive(3'd3, 16'h0300, 16'h0010, 1'b0, 1'b0, 1'b1, 16'h0);
      chk("R3 iflt taken pc", {16'd0, next_pc_o}, 32'h0310);
      drive(3'd3, 16'h0300, 16'h0010, 1'b0, 1'b1, 1'b0, 16'h0);
      chk("R3 iflt not taken pc", {16'd0, next_pc_o}, 32'h0302);
      chk("R3 iflt not taken", {31'd0, taken_o}, 32'h0);
      drive(3'd4, 16'h0300, 16'h0010, 1'b1, 1'b1, 1'b0, 16'h0);
      chk("R3 ifnlt taken pc", {16'd0, next_pc_o}, 32'h0310);
      chk("R3 ifnlt taken", {31'd0, taken_o}, 32'h1);
      drive(3'd4, 16'h0300, 16'h0010, 1'b1, 1'b0, 1'b1, 16'h0);
      chk("R3 ifnlt not taken pc", {16'd0, next_pc_o}, 32'h0304);
   endtask

   task automatic t_offsets;
      drive(3'd1, 16'h0100, 16'hFFF0, 1'b0, 1'b1, 1'b0, 16'h0);
      chk("R4 backward", {16'd0, next_pc_o}, 32'h00F0);
      drive(3'd1, 16'hFFF0, 16'h0020, 1'b0, 1'b1, 1'b0, 16'h0);
      chk("R4 forward wrap", {16'd0, next_pc_o}, 32'h0010);
      drive(3'd2, 16'h0004, 16'hFFF8, 1'b1, 1'b0, 1'b0, 16'h0);
      chk("R4 backward wrap", {16'd0, next_pc_o}, 32'hFFFC);
   endtask

   task automatic t_jumps;
      drive(3'd5, 16'h1234, 16'h09C4, 1'b1, 1'b0, 1'b1, 16'h5555);
      chk("R5 jabs pc", {16'd0, next_pc_o}, 32'h09C4);
      chk("R5 jabs taken", {31'd0, taken_o}, 32'h1);
      drive(3'd7, 16'h1234, 16'h09C4, 1'b0, 1'b1, 1'b0, 16'hBEEF);
      chk("R7 jreg pc", {16'd0, next_pc_o}, 32'hBEEF);
      chk("R7 jreg taken", {31'd0, taken_o}, 32'h1);
   endtask

   task automatic t_link;
      drive(3'd6, 16'h1234, 16'h0800, 1'b1, 1'b0, 1'b0, 16'h7777);
      chk("R6 jlink pc", {16'd0, next_pc_o}, 32'h0800);
      chk("R6 jlink we", {31'd0, link_we_o}, 32'h1);
      chk("R6 jlink idx", {28'd0, link_idx_o}, 32'hF);
      chk("R6 jlink val", {16'd0, link_val_o}, 32'h1236);
      drive(3'd6, 16'hFFFE, 16'h0800, 1'b0, 1'b1, 1'b1, 16'h0);
      chk("R6 jlink val wrap", {16'd0, link_val_o}, 32'h0000);
      for (int k = 0; k < 8; k++) begin
         if (k != 6) begin
            drive(3'(k), 16'h2000, 16'h0040, 1'b0, 1'b1, 1'b1, 16'h4000);
            chk("R8 no link", {31'd0, link_we_o}, 32'h0);
         end
      end
   endtask

   task automatic t_page;
      drive(3'd0, 16'h4000, 16'h0, 1'b0, 1'b0, 1'b0, 16'h0);
      page_val_i = 8'h5A; page_ld_i = 1'b1;
      @(negedge clk);
      page_ld_i = 1'b0; page_val_i = 8'hC3;
      #1;
      chk("R9 page load", {24'd0, page_o}, 32'h5A);
      chk("R9 fetch addr", {8'd0, fetch_addr_o}, 32'h5A4002);
      @(negedge clk);
      @(negedge clk);
      #1;
      chk("R9 page hold", {24'd0, page_o}, 32'h5A);
      page_val_i = 8'h01; page_ld_i = 1'b1;
      @(negedge clk);
      page_ld_i = 1'b0;
      drive(3'd5, 16'h0, 16'hABCD, 1'b0, 1'b0, 1'b0, 16'h0);
      chk("R9 fetch reload", {8'd0, fetch_addr_o}, 32'h01ABCD);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      t_reset;
      rst_n = 1'b1;
      t_sequential;
      t_zero_flag;
      t_lt_flag;
      t_offsets;
      t_jumps;
      t_link;
      t_page;
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule